// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencer

This block is the hardwired controller of a multi-cycle load/store processor. Each instruction is split into short clock cycles that reuse a single memory, a single ALU and a set of holding registers. The controller is a Moore state machine: every datapath control point is decoded from the current state only. The 6-bit opcode held in the instruction register only steers which state comes next.

Every instruction starts with the same two states: a fetch state and a decode/operand-read state. From decode the machine branches into a short tail chosen by the opcode. The tail is one to three states long, and its last state returns to fetch. Register writes, memory writes, PC updates and the state change all take effect on the clock edge that ends the state that requested them. Counting the two shared states, a branch or jump takes 3 cycles, a register-register operation or a store takes 4, and a load takes 5.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous reset), the machine enters the fetch state. After that edge, `phase` reads 0 and the outputs are the fetch outputs.
- R2: In fetch (`phase`=0) the outputs are: `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00 and `pc_src`=00. All other outputs are 0.
- R3: Fetch is always followed by decode (`phase`=1). In decode `alu_b_sel`=11, `alu_op`=00 and every other output is 0.
- R4: Opcode 100011 (load) runs through 0, 1, then 2, 3, 4, and then back to 0. In state 2 `alu_a_sel`=1 and `alu_b_sel`=10. In state 3 `mem_rd`=1 and `addr_sel`=1. In state 4 `reg_wr`=1, `wb_mem_sel`=1 and `dst_rd_sel`=0. Outputs not named are 0.
- R5: Opcode 101011 (store) runs through 0, 1, 2, 5 and then back to 0. State 2 is as in R4. In state 5 `mem_wr`=1 and `addr_sel`=1, and the rest are 0.
- R6: Opcode 000000 (register-register) runs through 0, 1, 6, 7 and then back to 0. In state 6 `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. In state 7 `reg_wr`=1 and `dst_rd_sel`=1. Outputs not named are 0.
- R7: Opcode 000100 (branch if equal) runs through 0, 1, 8 and then back to 0. In state 8 `pc_wr_cond`=1, `pc_src`=01, `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=01, and the rest are 0.
- R8: Opcode 000010 (jump) runs through 0, 1, 9 and then back to 0. In state 9 `pc_wr`=1 and `pc_src`=10, and the rest are 0.
- R9: Any other opcode in decode sends the machine straight back to fetch. No write enable (`mem_wr`, `reg_wr`, `pc_wr`, `pc_wr_cond`, `ir_wr`) is asserted in that decode cycle.
- R10: Outputs depend on the state only. Changing `opcode` within a cycle leaves every output unchanged until the next clock edge.
- R11: `mem_rd` and `mem_wr` are never both 1. At most one of `mem_wr`, `reg_wr` and `pc_wr_cond` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| phase | output | 4 | Current state code |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load enable |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by ALU zero |
| reg_wr | output | 1 | Register file write enable |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| wb_mem_sel | output | 1 | Register write data: 0 = ALU result register, 1 = memory data register |
| dst_rd_sel | output | 1 | Destination register: 0 = rt field, 1 = rd field |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 00 = B, 01 = constant 4, 10 = extended immediate, 11 = shifted immediate |
| alu_op | output | 2 | 00 add, 01 subtract, 10 use funct field |
| pc_src | output | 2 | PC source: 00 ALU output, 01 ALU result register, 10 jump target |

## Verification
The bench walks every opcode class through its whole tail and checks the state code and the full control word in each cycle. A wrong transition would show up as a skipped or extra state, for example a load missing its write-back or a store that reads memory. It changes the opcode in the middle of a cycle, which exposes any output that leaks straight from the opcode (Mealy-style). An undefined opcode is applied; a design that falls into a tail or asserts a write in decode would corrupt state. A reset is applied in the middle of a load; a design that resumes the tail instead of returning to fetch fails that check.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter int OPW = 6,
  parameter int SW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  output logic [SW-1:0]  phase,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_wr,
  output logic           pc_wr,
  output logic           pc_wr_cond,
  output logic           reg_wr,
  output logic           addr_sel,
  output logic           wb_mem_sel,
  output logic           dst_rd_sel,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic [1:0]     alu_op,
  output logic [1:0]     pc_src
);
  localparam logic [OPW-1:0] OP_RR  = OPW'(6'b000000);
  localparam logic [OPW-1:0] OP_LD  = OPW'(6'b100011);
  localparam logic [OPW-1:0] OP_ST  = OPW'(6'b101011);
  localparam logic [OPW-1:0] OP_BEQ = OPW'(6'b000100);
  localparam logic [OPW-1:0] OP_JMP = OPW'(6'b000010);

  localparam logic [SW-1:0] S_FETCH = SW'(0);
  localparam logic [SW-1:0] S_DEC   = SW'(1);
  localparam logic [SW-1:0] S_ADDR  = SW'(2);
  localparam logic [SW-1:0] S_MRD   = SW'(3);
  localparam logic [SW-1:0] S_LWB   = SW'(4);
  localparam logic [SW-1:0] S_MWR   = SW'(5);
  localparam logic [SW-1:0] S_EXE   = SW'(6);
  localparam logic [SW-1:0] S_RWB   = SW'(7);
  localparam logic [SW-1:0] S_BR    = SW'(8);
  localparam logic [SW-1:0] S_JMP   = SW'(9);

  logic [SW-1:0] cur, nxt;
  logic [15:0]   ctl;

  always_ff @(posedge clk)
    if (!rst_n) cur <= S_FETCH;
    else        cur <= nxt;

  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH: nxt = S_DEC;
      S_DEC: case (opcode)
        OP_LD, OP_ST: nxt = S_ADDR;
        OP_RR:        nxt = S_EXE;
        OP_BEQ:       nxt = S_BR;
        OP_JMP:       nxt = S_JMP;
        default:      nxt = S_FETCH;
      endcase
      S_ADDR:  nxt = (opcode == OP_ST) ? S_MWR : (opcode == OP_LD) ? S_MRD : S_FETCH;
      S_MRD:   nxt = S_LWB;
      S_EXE:   nxt = S_RWB;
      default: nxt = S_FETCH;
    endcase
  end

  always_comb
    case (cur)
      S_FETCH: ctl = 16'hB010;
      S_DEC:   ctl = 16'h0030;
      S_ADDR:  ctl = 16'h0060;
      S_MRD:   ctl = 16'h8200;
      S_LWB:   ctl = 16'h0500;
      S_MWR:   ctl = 16'h4200;
      S_EXE:   ctl = 16'h0048;
      S_RWB:   ctl = 16'h0480;
      S_BR:    ctl = 16'h0845;
      S_JMP:   ctl = 16'h1002;
      default: ctl = 16'h0000;
    endcase

  assign phase = cur;
  assign {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr, addr_sel,
          wb_mem_sel, dst_rd_sel, alu_a_sel, alu_b_sel, alu_op, pc_src} = ctl;
endmodule

module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] opcode,
  input logic [3:0] phase,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       reg_wr,
  input logic       pc_wr_cond
);
  p_reset_fetch_r1: assert property (@(posedge clk) !rst_n |=> phase == 4'd0);
  p_decode_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 4'd0 |=> phase == 4'd1);
  p_load_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 4'd3 |=> phase == 4'd4);
  p_exec_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 4'd6 |=> phase == 4'd7);
  p_tail_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 4'd4 || phase == 4'd5 || phase == 4'd7 || phase == 4'd8 || phase == 4'd9)
    |=> phase == 4'd0);
  p_bad_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 4'd1 && opcode != 6'h00 && opcode != 6'h23 && opcode != 6'h2B &&
     opcode != 6'h04 && opcode != 6'h02) |=> phase == 4'd0);
  p_mem_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_one_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, reg_wr, pc_wr_cond}));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .phase(phase),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .reg_wr(reg_wr), .pc_wr_cond(pc_wr_cond)
);

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;
  logic clk = 0, rst_n = 0;
  logic [5:0] opcode = 6'h00;
  logic [3:0] phase;
  logic mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr;
  logic addr_sel, wb_mem_sel, dst_rd_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mc_ctrl_fsm u_dut (.*);

  // [31:26] opcode, [25:23] cycles, [19:0] state list, 4 bits per cycle
  localparam logic [31:0] VEC [6] = '{
    {6'b000000, 3'd4, 3'd0, 20'h00_7610},
    {6'b100011, 3'd5, 3'd0, 20'h4_3210},
    {6'b101011, 3'd4, 3'd0, 20'h0_5210},
    {6'b000100, 3'd3, 3'd0, 20'h0_0810},
    {6'b000010, 3'd3, 3'd0, 20'h0_0910},
    {6'b111111, 3'd2, 3'd0, 20'h0_0010}
  };

  function automatic logic [15:0] pack(input logic rd, wr, ir, pw, pwc, rw, as, wm, dr, aa,
                                       input logic [1:0] ab, op, ps);
    return {rd, wr, ir, pw, pwc, rw, as, wm, dr, aa, ab, op, ps};
  endfunction

  function automatic logic [15:0] expect_ctl(input logic [3:0] s);
    case (s)
      4'd0: return pack(1,0,1,1,0,0,0,0,0,0,2'b01,2'b00,2'b00);
      4'd1: return pack(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00);
      4'd2: return pack(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00);
      4'd3: return pack(1,0,0,0,0,0,1,0,0,0,2'b00,2'b00,2'b00);
      4'd4: return pack(0,0,0,0,0,1,0,1,0,0,2'b00,2'b00,2'b00);
      4'd5: return pack(0,1,0,0,0,0,1,0,0,0,2'b00,2'b00,2'b00);
      4'd6: return pack(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00);
      4'd7: return pack(0,0,0,0,0,1,0,0,1,0,2'b00,2'b00,2'b00);
      4'd8: return pack(0,0,0,0,1,0,0,0,0,1,2'b00,2'b01,2'b01);
      4'd9: return pack(0,0,0,1,0,0,0,0,0,0,2'b00,2'b00,2'b10);
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] got_ctl();
    return {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr, addr_sel,
            wb_mem_sel, dst_rd_sel, alu_a_sel, alu_b_sel, alu_op, pc_src};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string req, input logic [3:0] s);
    check({req, " state"}, 32'(phase), 32'(s));
    check({req, " controls"}, 32'(got_ctl()), 32'(expect_ctl(s)));
  endtask

  function automatic string req_of(input logic [5:0] op);
    case (op)
      6'b100011: return "R4";
      6'b101011: return "R5";
      6'b000000: return "R6";
      6'b000100: return "R7";
      6'b000010: return "R8";
      default:   return "R9";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] hold;
    repeat (2) @(negedge clk);
    check_state("R1", 4'd0);
    rst_n = 1;

    for (int v = 0; v < 6; v++) begin
      logic [5:0] op;
      int n;
      op = VEC[v][31:26];
      n  = int'(VEC[v][25:23]);
      opcode = op;
      check_state("R2", 4'd0);
      for (int k = 1; k < n; k++) begin
        @(negedge clk);
        check_state(k == 1 ? "R3" : req_of(op), VEC[v][4*k +: 4]);
        if (k == 1 && req_of(op) == "R9")
          check("R9 no write in decode", 32'({mem_wr, reg_wr, pc_wr, pc_wr_cond, ir_wr}), 32'h0);
      end
      @(negedge clk);
      check_state({req_of(op), " return"}, 4'd0);
    end

    // R10: opcode changes within a cycle must not move any output
    opcode = 6'b000000;
    @(negedge clk);
    @(negedge clk);
    check("R10 in exec", 32'(phase), 32'd6);
    hold = got_ctl();
    #2 opcode = 6'b100011;
    #1 check("R10 exec outputs", 32'(got_ctl()), 32'(hold));
    #1 opcode = 6'b000100;
    #1 check("R10 exec outputs", 32'(got_ctl()), 32'(hold));
    #1 opcode = 6'b000000;
    @(negedge clk);
    check_state("R6 after opcode toggle", 4'd7);
    @(negedge clk);
    check_state("R10 fetch", 4'd0);
    hold = got_ctl();
    #2 opcode = 6'b101011;
    #1 check("R10 fetch outputs", 32'(got_ctl()), 32'(hold));
    @(negedge clk);
    hold = got_ctl();
    #2 opcode = 6'b000010;
    #1 check("R10 decode outputs", 32'(got_ctl()), 32'(hold));
    @(negedge clk);
    check_state("R8 late opcode", 4'd9);
    @(negedge clk);

    // R1: reset in the middle of a load
    opcode = 6'b100011;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check_state("R4 mid load", 4'd3);
    rst_n = 0;
    @(negedge clk);
    check_state("R1 mid reset", 4'd0);
    rst_n = 1;
    @(negedge clk);
    check_state("R3 after reset", 4'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule